// File: doc/BRIEF.md
# Period-Match Timer with Pre- and Postscaler

The block is an 8-bit up-counter that advances on an instruction-rate tick after that tick has passed through a selectable divider (1, 4 or 16). The count is compared with a programmable period value. When the two are equal on a divided tick, the count restarts from zero on that same tick and a single-cycle match pulse leaves the block. The pulse is exported for a serial shift-clock user and also feeds a 4-bit postscaler. Once the postscaler has seen its programmed number of matches, it raises a sticky interrupt flag.

Software reaches the block through a plain register port with four addresses. The write and read sides are separate and the read data is combinational. The count register, the period register, a control byte and a one-bit flag register are all accessible. The control byte holds the enable bit, the prescale field and the postscale field. A write to the count or to the control byte restarts both dividers. The port has no flow control: every write strobe is accepted in the cycle it is presented.

Top module: `period_timer`

## Requirements
- R1: After reset the count reads 0, the period reads 0xFF, the control byte reads 0x00, the flag reads 0, and match_o and irq_o are low.
- R2: Control bits [1:0] select the tick divider: 00 divides by 1, 01 divides by 4, and 10 or 11 divide by 16.
- R3: On each divided tick the count increments. If the count equals the period, it instead returns to 0, and match_o is high for exactly that cycle.
- R4: Control bits [6:3] hold a value N. The flag sets after every N+1 match pulses, so 0000 sets it on every match and 1111 sets it on every sixteenth.
- R5: The flag is bit 0 of address 3 and drives irq_o. It stays set until software writes 0 to it. A hardware set in the same cycle as that write wins.
- R6: With control bit 2 at 0 the count does not move, and no match pulse or flag set occurs.
- R7: Control bit 7 is not stored and always reads as 0.
- R8: A write to address 0 loads the count and restarts the tick divider and the postscaler from zero.
- R9: A write to the control byte (address 2) restarts the tick divider and the postscaler but leaves the count unchanged.
- R10: The count (address 0) and the period (address 1) read back the values written to them.
- R11: While tick_i is low the count does not advance, even with the timer enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Instruction-rate tick enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Write address: 0 count, 1 period, 2 control, 3 flag |
| wr_data_i | input | 8 | Write data |
| rd_addr_i | input | 2 | Read address, same map as the write address |
| rd_data_o | output | 8 | Combinational read data |
| match_o | output | 1 | One-cycle pulse when the count wraps at the period |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
Two collisions matter in this block. The first is a hardware set of the flag in the same cycle as a software write of 0 to it. The bench provokes this with a period of 0 and a 1:1 postscaler, so a match arrives on every clock, and then writes 0 to the flag. irq_o must still be high afterwards. The second is a divider restart in the same cycle as a pending tick or match. After a control write or a count write issued in mid-phase, the bench checks that the count holds for a full divider period and that the flag needs a full postscale run of fresh matches.

// File: rtl/ptmr_pkg.sv
`timescale 1ns/1ps
package ptmr_pkg;
  localparam int PRE_W  = 4;
  localparam int POST_W = 4;

  typedef enum logic [1:0] {
    REG_COUNT  = 2'd0,
    REG_PERIOD = 2'd1,
    REG_CTRL   = 2'd2,
    REG_FLAG   = 2'd3
  } ptmr_reg_e;

  // terminal count of the tick divider for a prescale select code
  function automatic logic [PRE_W-1:0] pre_last(input logic [1:0] sel);
    case (sel)
      2'b00:   return PRE_W'(0);
      2'b01:   return PRE_W'(3);
      default: return PRE_W'(15);
    endcase
  endfunction
endpackage

// File: rtl/ptmr_prescaler.sv
`timescale 1ns/1ps
module ptmr_prescaler
  import ptmr_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr_i,
  input  logic       adv_i,
  input  logic [1:0] sel_i,
  output logic       tick_o
);
  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] last;

  assign last   = pre_last(sel_i);
  assign tick_o = adv_i && !clr_i && (pre_q == last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              pre_q <= '0;
    else if (clr_i)          pre_q <= '0;
    else if (adv_i) begin
      if (pre_q == last)     pre_q <= '0;
      else                   pre_q <= pre_q + 1'b1;
    end
  end

  // R8
  pre_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (pre_q == '0));
  // R2
  pre_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= last);
  // R6
  pre_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!adv_i && !clr_i) |=> $stable(pre_q));
endmodule

// File: rtl/ptmr_counter.sv
`timescale 1ns/1ps
module ptmr_counter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] load_val_i,
  input  logic          step_i,
  input  logic [DW-1:0] period_i,
  output logic [DW-1:0] cnt_o,
  output logic          match_o
);
  logic [DW-1:0] cnt_q;

  assign cnt_o   = cnt_q;
  assign match_o = step_i && (cnt_q == period_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (step_i)  cnt_q <= (cnt_q == period_i) ? '0 : cnt_q + 1'b1;
  end

  // R3
  wrap_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (match_o && !load_i) |=> (cnt_q == '0));
  // R6
  cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(cnt_q));
  // R8
  load_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load_i && step_i));
endmodule

// File: rtl/ptmr_postscaler.sv
`timescale 1ns/1ps
module ptmr_postscaler
  import ptmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              match_i,
  input  logic [POST_W-1:0] sel_i,
  output logic              set_o
);
  logic [POST_W-1:0] post_q;

  assign set_o = match_i && !clr_i && (post_q == sel_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        post_q <= '0;
    else if (clr_i)    post_q <= '0;
    else if (match_i)  post_q <= (post_q == sel_i) ? '0 : post_q + 1'b1;
  end

  // R4
  post_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_o |=> (post_q == '0));
  // R9
  post_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (post_q == '0));
endmodule

// File: rtl/period_timer.sv
`timescale 1ns/1ps
module period_timer
  import ptmr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [1:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [1:0]    rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          match_o,
  output logic          irq_o
);
  localparam int CTRL_W = 7;

  logic [CTRL_W-1:0] ctrl_q;
  logic [DW-1:0]     period_q;
  logic              flag_q;
  logic [DW-1:0]     cnt;
  logic              wr_cnt, wr_per, wr_ctl, wr_flg, clr;
  logic              pre_tick, flag_set;
  logic              run_en;
  logic [1:0]        pre_sel;
  logic [POST_W-1:0] post_sel;

  assign wr_cnt   = wr_en_i && (wr_addr_i == REG_COUNT);
  assign wr_per   = wr_en_i && (wr_addr_i == REG_PERIOD);
  assign wr_ctl   = wr_en_i && (wr_addr_i == REG_CTRL);
  assign wr_flg   = wr_en_i && (wr_addr_i == REG_FLAG);
  assign clr      = wr_cnt || wr_ctl;
  assign run_en   = ctrl_q[2];
  assign pre_sel  = ctrl_q[1:0];
  assign post_sel = ctrl_q[6:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q   <= '0;
      period_q <= '1;
      flag_q   <= 1'b0;
    end else begin
      if (wr_ctl) ctrl_q   <= wr_data_i[CTRL_W-1:0];
      if (wr_per) period_q <= wr_data_i;
      if (flag_set)    flag_q <= 1'b1;
      else if (wr_flg) flag_q <= wr_data_i[0];
    end
  end

  ptmr_prescaler u_pre (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr_i  (clr),
    .adv_i  (tick_i && run_en),
    .sel_i  (pre_sel),
    .tick_o (pre_tick)
  );

  ptmr_counter #(.DW(DW)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_i     (wr_cnt),
    .load_val_i (wr_data_i),
    .step_i     (pre_tick),
    .period_i   (period_q),
    .cnt_o      (cnt),
    .match_o    (match_o)
  );

  ptmr_postscaler u_post (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr_i   (clr),
    .match_i (match_o),
    .sel_i   (post_sel),
    .set_o   (flag_set)
  );

  assign irq_o = flag_q;

  always_comb begin
    rd_data_o = '0;
    case (rd_addr_i)
      REG_COUNT:  rd_data_o = cnt;
      REG_PERIOD: rd_data_o = period_q;
      REG_CTRL:   rd_data_o = DW'(ctrl_q);
      default:    rd_data_o = DW'(flag_q);
    endcase
  end

  // R5
  flag_set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flag_set |=> irq_o);
  // R5
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !wr_flg) |=> irq_o);
  // R7
  ctrl_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == REG_CTRL) |-> (rd_data_o[7] == 1'b0));
  // R9
  ctl_keeps_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ctl |=> $stable(cnt));
  // R6
  idle_no_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> !match_o);
endmodule

// File: tb/tb_period_timer.sv
`timescale 1ns/1ps
module tb_period_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick_i = 1'b1;
  logic       wr_en = 1'b0;
  logic [1:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [1:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic       match_o, irq_o;

  int total = 0;
  int fails = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  period_timer dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .match_o(match_o), .irq_o(irq_o)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    wr_addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic setup(input int p, input int c);
    wr(2'd2, 8'h00);
    wr(2'd1, 8'(p));
    wr(2'd0, 8'h00);
    wr(2'd3, 8'h00);
    wr(2'd2, 8'(c));
  endtask

  // reference stepping derived from R2/R3/R4
  task automatic run(input int p, input int c, input int r, input int post, input int n, input string req);
    int cnt = 0, pc = 0, posc = 0, v;
    bit flag = 0, m;
    setup(p, c);
    for (int i = 0; i < n; i++) begin
      m = (pc == r - 1) && (cnt == p);
      rd(2'd0, v);
      chk(req, "count", v, cnt);
      chk(req, "match", int'(match_o), int'(m));
      chk("R4", "irq", int'(irq_o), int'(flag));
      if (pc == r - 1) begin
        pc = 0;
        if (cnt == p) begin
          cnt = 0;
          if (posc == post) begin posc = 0; flag = 1; end
          else posc++;
        end else cnt++;
      end else pc++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int v;
    rd(2'd0, v); chk("R1", "count", v, 0);
    rd(2'd1, v); chk("R1", "period", v, 255);
    rd(2'd2, v); chk("R1", "ctrl", v, 0);
    rd(2'd3, v); chk("R1", "flag", v, 0);
    chk("R1", "match", int'(match_o), 0);
    chk("R1", "irq", int'(irq_o), 0);
    @(negedge clk);
  endtask

  task automatic t_readback();
    int v;
    wr(2'd2, 8'h00);
    wr(2'd1, 8'hA5);
    wr(2'd0, 8'h3C);
    rd(2'd1, v); chk("R10", "period", v, 8'hA5);
    rd(2'd0, v); chk("R10", "count", v, 8'h3C);
    @(negedge clk);
  endtask

  task automatic t_bit7();
    int v;
    wr(2'd2, 8'hFB);
    rd(2'd2, v); chk("R7", "ctrl", v, 8'h7B);
    wr(2'd2, 8'h00);
  endtask

  task automatic t_hold();
    int v;
    setup(5, 8'h05);
    repeat (10) @(negedge clk);
    rd(2'd0, v); chk("R2", "count before hold", v, 2);
    wr(2'd2, 8'h01);
    for (int j = 0; j < 12; j++) begin
      rd(2'd0, v); chk("R6", "held count", v, 2);
      chk("R6", "match", int'(match_o), 0);
      @(negedge clk);
    end
    tick_i = 1'b0;
    wr(2'd2, 8'h04);
    rd(2'd0, v); chk("R9", "count after ctrl write", v, 2);
    repeat (8) @(negedge clk);
    rd(2'd0, v); chk("R11", "count with tick low", v, 2);
    tick_i = 1'b1;
    @(negedge clk);
    rd(2'd0, v); chk("R11", "count after tick back", v, 3);
    @(negedge clk);
  endtask

  task automatic t_ctrl_clear();
    int v;
    setup(255, 8'h05);
    repeat (6) @(negedge clk);
    wr(2'd2, 8'h05);
    for (int j = 0; j < 4; j++) begin
      rd(2'd0, v); chk("R9", "count kept, divider restarted", v, 1);
      @(negedge clk);
    end
    rd(2'd0, v); chk("R9", "count after full divide", v, 2);
    // postscaler restart: 1:2, match every clock
    setup(0, 8'h0C);
    @(negedge clk);
    wr(2'd2, 8'h0C);
    chk("R9", "irq after restart", int'(irq_o), 0);
    @(negedge clk);
    chk("R9", "irq one match later", int'(irq_o), 0);
    @(negedge clk);
    chk("R9", "irq two matches later", int'(irq_o), 1);
  endtask

  task automatic t_count_clear();
    int v;
    setup(255, 8'h05);
    repeat (6) @(negedge clk);
    wr(2'd0, 8'h10);
    for (int j = 0; j < 4; j++) begin
      rd(2'd0, v); chk("R8", "loaded count", v, 16);
      @(negedge clk);
    end
    rd(2'd0, v); chk("R8", "count after full divide", v, 17);
    setup(0, 8'h0C);
    @(negedge clk);
    wr(2'd0, 8'h00);
    @(negedge clk);
    chk("R8", "irq one match after load", int'(irq_o), 0);
    @(negedge clk);
    chk("R8", "irq two matches after load", int'(irq_o), 1);
  endtask

  task automatic t_flag();
    int v;
    setup(0, 8'h04);
    @(negedge clk);
    chk("R5", "irq set", int'(irq_o), 1);
    wr(2'd3, 8'h00);
    chk("R5", "set beats clear", int'(irq_o), 1);
    wr(2'd2, 8'h00);
    repeat (3) @(negedge clk);
    chk("R5", "sticky while idle", int'(irq_o), 1);
    wr(2'd3, 8'h00);
    rd(2'd3, v); chk("R5", "cleared flag", v, 0);
    chk("R5", "irq cleared", int'(irq_o), 0);
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_readback();
    run(3, 8'h04, 1, 0, 12, "R3");
    run(2, 8'h0D, 4, 1, 40, "R2");
    run(1, 8'h16, 16, 2, 200, "R2");
    run(1, 8'h17, 16, 2, 200, "R2");
    run(0, 8'h7C, 1, 15, 20, "R4");
    t_bit7();
    t_hold();
    t_ctrl_clear();
    t_count_clear();
    t_flag();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end
endmodule